// File: doc/BRIEF.md
# Fastlock Timeout Mode Controller

This block decides how a synthesizer's fastlock switch pin is driven and whether the charge pump runs at its normal or its quadrupled current. Software writes a timeout word through a latch strobe. Small word values pick fixed pin and current settings. Larger values start a timed fastlock burst. During the burst the pin is pulled low and the pump runs at 4x current. The block counts phase-detector reference events, and once the programmed number has been seen it falls back to normal operation by itself.

The block has no data path, so every pin is a plain control or status signal with no handshake. The current-scale output is a combinational function of the registered mode, the normal-current bit and power-down. A change on either of those two inputs therefore shows up on the output in the same cycle. A latched word takes effect in the cycle after the strobe edge.

Top module: `fl_timeout_ctrl`

## Requirements
- R1: After reset the mode is off and no countdown is pending: `fl_oe_o`=0, `fl_drv_o`=0, `tmo_busy_o`=0, and `cp_x4_o` equals `cp_hi_i`.
- R2: Word value 0 (off): `fl_oe_o`=0, `fl_drv_o`=0, `cp_x4_o` follows `cp_hi_i`.
- R3: Word value 1 (manual fastlock): `fl_oe_o`=1, `fl_drv_o`=0, `cp_x4_o`=1. This holds for as long as no new word is latched, and reference events have no effect on it.
- R4: Word value 2: `fl_oe_o`=1, `fl_drv_o`=0, `cp_x4_o` follows `cp_hi_i`.
- R5: Word value 3: `fl_oe_o`=1, `fl_drv_o`=1, `cp_x4_o` follows `cp_hi_i`.
- R6: A word value N of 4 or more gives `fl_oe_o`=1, `fl_drv_o`=0, `cp_x4_o`=1 and `tmo_busy_o`=1 from the cycle after the strobe edge.
- R7: In timed mode, each clock edge with `ref_evt_i` high (and power-down low, no strobe) counts one event. At the edge that samples the N-th event the block returns to the off behaviour of R2 and `tmo_busy_o` falls.
- R8: `cp_hi_i` acts on `cp_x4_o` combinationally, in the same cycle, with no synchronisation to any event.
- R9: A strobe aborts any countdown in progress and reloads the count from the new word. A reference event in the same cycle as a strobe is not counted.
- R10: While `pwr_dn_i` is high: `fl_oe_o`=0, `fl_drv_o`=0, `cp_x4_o`=0. The countdown is frozen, and reference events in that time are not counted. Once power-down ends, the countdown resumes where it stopped.
- R11: `tmo_busy_o` is high exactly while a timed countdown is pending, power-down included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmo_load_i | input | 1 | Latch strobe for the timeout word |
| tmo_word_i | input | WORD_W | Timeout word, unsigned binary |
| cp_hi_i | input | 1 | Normal-current bit, 1 selects 4x when not forced |
| ref_evt_i | input | 1 | One-cycle phase-detector reference event |
| pwr_dn_i | input | 1 | Power-down |
| fl_drv_o | output | 1 | Fastlock pin drive level |
| fl_oe_o | output | 1 | Fastlock pin output enable (0 = high impedance) |
| cp_x4_o | output | 1 | Charge-pump current scale, 1 = 4x |
| tmo_busy_o | output | 1 | Timed countdown pending |

## Verification
The bench builds the block with WORD_W = 8 rather than the default 12. With that width the largest code, 255, can be counted all the way down inside a short run, and the random word draws land on each of the four static codes often. The static/timed boundary is exercised directly at codes 3 and 4, and the expiry edge is exercised at a count of exactly one remaining event. Power-down, the normal-current bit and the strobes are mixed in at random.

// File: rtl/fl_pkg.sv
package fl_pkg;
  typedef enum logic [2:0] {
    FL_OFF      = 3'd0,
    FL_MANUAL   = 3'd1,
    FL_PIN_LOW  = 3'd2,
    FL_PIN_HIGH = 3'd3,
    FL_TIMED    = 3'd4
  } fl_mode_e;

  localparam int unsigned FL_STATIC_CODES = 4;
endpackage

// File: rtl/fl_decode.sv
module fl_decode
  import fl_pkg::*;
#(
  parameter int unsigned WORD_W = 12
) (
  input  logic [WORD_W-1:0] word_i,
  output fl_mode_e          mode_o,
  output logic              timed_o
);
  localparam logic [WORD_W-1:0] STATIC_LIMIT = WORD_W'(FL_STATIC_CODES);

  always_comb begin
    timed_o = (word_i >= STATIC_LIMIT);
    if (timed_o) begin
      mode_o = FL_TIMED;
    end else begin
      unique case (word_i[1:0])
        2'd0:    mode_o = FL_OFF;
        2'd1:    mode_o = FL_MANUAL;
        2'd2:    mode_o = FL_PIN_LOW;
        default: mode_o = FL_PIN_HIGH;
      endcase
    end
  end
endmodule

// File: rtl/fl_timer.sv
module fl_timer #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             timed_i,
  input  logic             tick_i,
  input  logic             hold_i,
  output logic             active_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             count_en;

  assign count_en = active_q & tick_i & ~hold_i & ~load_i;
  assign expire_o = count_en & (cnt_q == ONE);
  assign active_o = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      cnt_q    <= load_val_i;
      active_q <= timed_i;
    end else if (count_en) begin
      cnt_q    <= cnt_q - ONE;
      active_q <= (cnt_q != ONE);
    end
  end

  // R10: the count is frozen while power-down holds it and no strobe arrives
  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !load_i) |=> $stable(cnt_q));
  // R9: a strobe reloads the count from the new word
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
  // R7: the last counted event ends the countdown
  a_r7_expire: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !active_q);
  // R11: a pending countdown never sits at zero
  a_r11_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q != '0));
endmodule

// File: rtl/fl_drive.sv
module fl_drive
  import fl_pkg::*;
(
  input  fl_mode_e mode_i,
  input  logic     cp_hi_i,
  input  logic     pwr_dn_i,
  output logic     drv_o,
  output logic     oe_o,
  output logic     x4_o
);
  always_comb begin
    drv_o = 1'b0;
    oe_o  = 1'b0;
    x4_o  = cp_hi_i;
    if (pwr_dn_i) begin
      x4_o = 1'b0;
    end else begin
      unique case (mode_i)
        FL_MANUAL, FL_TIMED: begin
          oe_o = 1'b1;
          x4_o = 1'b1;
        end
        FL_PIN_LOW: oe_o = 1'b1;
        FL_PIN_HIGH: begin
          oe_o  = 1'b1;
          drv_o = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fl_timeout_ctrl.sv
module fl_timeout_ctrl
  import fl_pkg::*;
#(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmo_load_i,
  input  logic [WORD_W-1:0] tmo_word_i,
  input  logic              cp_hi_i,
  input  logic              ref_evt_i,
  input  logic              pwr_dn_i,
  output logic              fl_drv_o,
  output logic              fl_oe_o,
  output logic              cp_x4_o,
  output logic              tmo_busy_o
);
  fl_mode_e dec_mode;
  logic     dec_timed;
  fl_mode_e mode_q;
  logic     tmr_active;
  logic     tmr_expire;

  fl_decode #(.WORD_W(WORD_W)) u_decode (
    .word_i  (tmo_word_i),
    .mode_o  (dec_mode),
    .timed_o (dec_timed)
  );

  fl_timer #(.CNT_W(WORD_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmo_load_i),
    .load_val_i (tmo_word_i),
    .timed_i    (dec_timed),
    .tick_i     (ref_evt_i),
    .hold_i     (pwr_dn_i),
    .active_o   (tmr_active),
    .expire_o   (tmr_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= FL_OFF;
    end else if (tmo_load_i) begin
      mode_q <= dec_mode;
    end else if (tmr_expire) begin
      mode_q <= FL_OFF;
    end
  end

  fl_drive u_drive (
    .mode_i   (mode_q),
    .cp_hi_i  (cp_hi_i),
    .pwr_dn_i (pwr_dn_i),
    .drv_o    (fl_drv_o),
    .oe_o     (fl_oe_o),
    .x4_o     (cp_x4_o)
  );

  assign tmo_busy_o = tmr_active;

  // R6: a pending countdown outside power-down pulls the pin low at 4x
  a_r6_timed_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_busy_o && !pwr_dn_i) |-> (fl_oe_o && !fl_drv_o && cp_x4_o));
  // R10: power-down releases the pin and selects 1x
  a_r10_pd_safe: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn_i |-> (!fl_oe_o && !fl_drv_o && !cp_x4_o));
  // R11: the timer and the registered mode agree on timed operation
  a_r11_busy_mode: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_busy_o == (mode_q == FL_TIMED));
  // R3: manual fastlock survives reference events
  a_r3_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == FL_MANUAL && !tmo_load_i) |=> (mode_q == FL_MANUAL));
  // R2: with the pin released, the drive level is low
  a_r2_released_low: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_o |-> !fl_drv_o);
endmodule

// File: tb/fl_timeout_ctrl_tb.sv
module fl_timeout_ctrl_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld = 1'b0;
  logic [W-1:0] word = '0;
  logic         cp = 1'b0;
  logic         rf = 1'b0;
  logic         pd = 1'b0;
  logic         drv, oe, x4, busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  int m_kind = 0;   // 0 off, 1 manual, 2 pin low, 3 pin high, 4 timed
  int m_cnt  = 0;
  bit m_busy = 1'b0;

  always #5 clk = ~clk;

  fl_timeout_ctrl #(.WORD_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tmo_load_i(ld), .tmo_word_i(word),
    .cp_hi_i(cp), .ref_evt_i(rf), .pwr_dn_i(pd),
    .fl_drv_o(drv), .fl_oe_o(oe), .cp_x4_o(x4), .tmo_busy_o(busy)
  );

  function automatic string kind_tag(int k);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [3:0] expect_out(int k, bit b, logic c, logic p);
    logic e_oe, e_drv, e_x4;
    e_oe = 1'b0; e_drv = 1'b0; e_x4 = c;
    if (p) e_x4 = 1'b0;
    else if (k == 1 || k == 4) begin e_oe = 1'b1; e_x4 = 1'b1; end
    else if (k == 2) e_oe = 1'b1;
    else if (k == 3) begin e_oe = 1'b1; e_drv = 1'b1; end
    return {e_oe, e_drv, e_x4, b};
  endfunction

  task automatic check_out(input string tag);
    logic [3:0] e;
    string t;
    e = expect_out(m_kind, m_busy, cp, pd);
    t = (tag == "") ? (pd ? "R10" : kind_tag(m_kind)) : tag;
    checks++;
    if ({oe, drv, x4, busy} !== e) begin
      errors++;
      $display("FAIL %s oe/drv/x4/busy act %b exp %b (kind %0d cnt %0d)",
               t, {oe, drv, x4, busy}, e, m_kind, m_cnt);
    end
  endtask

  task automatic step(input logic l, input int w, input logic r,
                      input logic p, input logic c, input string tag);
    @(negedge clk);
    ld = l; word = W'(w); rf = r; pd = p; cp = c;
    #1;
    check_out(tag);           // R8: cp acts within the cycle
    if (l) begin
      m_kind = (w < 4) ? w : 4;
      m_cnt  = w;
      m_busy = (w >= 4);
    end else if (r && m_busy && !p) begin
      m_cnt--;
      if (m_cnt == 0) begin m_busy = 1'b0; m_kind = 0; end
    end
    @(posedge clk);
    #2;
    check_out(tag);
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset state, cp high passes through
    cp = 1'b1;
    #23;
    check_out("R1");
    rst_n = 1'b1;
    step(0, 0, 1, 0, 1, "R1");
    step(0, 0, 0, 0, 0, "R1");
    // R2..R5 static codes, cp toggled (R8)
    for (int k = 0; k < 4; k++) begin
      step(1, k, 0, 0, 0, "");
      step(0, 0, 1, 0, 1, "R8");
      step(0, 0, 1, 0, 0, "R8");
    end
    // R3: manual stays on under many events
    step(1, 1, 1, 0, 0, "R3");
    for (int i = 0; i < 20; i++) step(0, 0, 1, 0, 0, "R3");
    // R6/R7: code 4 counts exactly four events, with gaps
    step(1, 4, 0, 0, 0, "R6");
    step(0, 0, 1, 0, 0, "R7");
    step(0, 0, 0, 0, 1, "R7");
    step(0, 0, 1, 0, 0, "R7");
    step(0, 0, 1, 0, 1, "R7");
    step(0, 0, 1, 0, 1, "R7");  // fourth event: expire
    step(0, 0, 1, 0, 0, "R7");
    // R9: strobe with event in same cycle, then abort and reload
    step(1, 5, 1, 0, 0, "R9");
    step(0, 0, 1, 0, 0, "R9");
    step(1, 6, 1, 0, 0, "R9");
    for (int i = 0; i < 7; i++) step(0, 0, 1, 0, 0, "R9");
    // R10: power-down freezes, then resumes
    step(1, 4, 0, 0, 1, "R10");
    step(0, 0, 1, 0, 1, "R10");
    for (int i = 0; i < 6; i++) step(0, 0, 1, 1, 1, "R10");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 1, "R10");
    // R11: largest code runs to completion
    step(1, 255, 0, 0, 0, "R11");
    for (int i = 0; i < 257; i++) step(0, 0, 1, 0, 0, "R11");
    // boundary: strobing code 3 ends a countdown
    step(1, 9, 0, 0, 0, "R9");
    step(1, 3, 1, 0, 1, "R9");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic l, r, p, c;
      int w;
      l = ($urandom % 30) == 0;
      w = ($urandom % 2) ? int'($urandom % 8) : int'($urandom % 256);
      r = $urandom % 2;
      p = ($urandom % 12) == 0;
      c = $urandom % 2;
      step(l, w, r, p, c, "");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule